// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block is the software-visible face of a multi-channel event timer. A 32-bit request/response bus reaches a 1 KiB register window. The window holds a read-only capability word pair, a global configuration word, a write-one-to-clear status word and a 64-bit free-running main counter. Behind these sit the per-channel registers: each channel has a configuration, a 64-bit comparator and a 64-bit route word. Each channel block sits at a fixed 32-byte stride starting at byte offset 0x100.

The main counter advances by one on every cycle where the `tick` strobe is high and the global run bit is set. It holds its value while the run bit is clear. Software may load either 32-bit half at any time. Each channel is armed when the run bit turns on, provided its comparator is not all ones. A channel is also armed when its comparator is written while running. Every channel is disarmed, and its status cleared, when the run bit turns off. An armed and enabled channel fires when the counter steps off its comparator value. In level mode the firing latches a status bit that drives `evt`. In edge mode it gives a single-cycle pulse on `evt`.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the counter reads 0, global configuration 0, status 0, every comparator reads all ones, `rvalid` and `evt` are low.
- R2: Every request gets `rvalid` high in exactly the next cycle, with read data for that request. Without a request, `rvalid` is low in the next cycle.
- R3: Byte offset 0x000 reads {18'b0, bit13=1 (64-bit counter), bits12:8 = channel count minus one, bits7:0 = 0x01}. Offset 0x004 reads the tick period parameter. Writes to both offsets are ignored.
- R4: With global bit0 (run) set, each cycle with `tick` high adds one to the 64-bit counter, with carry into the high half. With run clear, the counter holds.
- R5: A write to 0x0F0 replaces the counter low half and a write to 0x0F4 replaces the high half, even while running. A read returns the count of the request cycle.
- R6: In the global configuration at 0x010 only bits 1:0 are writable. Offset 0x014 reads 0 and ignores writes.
- R7: Channel n occupies 0x100+0x20*n. Its word offsets are +0x08/+0x0C for the comparator low/high and +0x10/+0x14 for the route low/high. All of these read back what was written.
- R8: In channel configuration +0x00, bit1 (level mode), bit2 (enable) and bit3 (periodic) are writable. Bits 4 and 5 read as 1 and all other bits read 0. The +0x04 word reads 0x4 and ignores writes.
- R9: Channel slots at or beyond the implemented count, and unmapped offsets, read 0. Writes to them change no implemented register.
- R10: A rising run bit arms each channel whose comparator is not all ones. A comparator write while running arms the channel. A falling run bit disarms all channels and clears all status bits.
- R11: An armed, enabled channel fires on a counted tick where the counter equals its comparator. In level mode (bit1=1) the firing sets status bit n, which `evt[n]` follows. In edge mode it gives one one-cycle `evt[n]` pulse and sets no status.
- R12: Writing the status word at 0x020 clears exactly the bits written as 1. Bits written as 0 stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance strobe |
| req | input | 1 | Access request, one cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Response valid, one cycle after req |
| rdata | output | 32 | Read data |
| evt | output | clamped channel count | Per-channel event output |

## Verification
Read data and `rvalid` appear one cycle after the request cycle. The bench drives each access on a falling edge and samples the response on the next falling edge. Counter effects of `tick` land at the edge that sees the strobe, so the expected count is updated per counted tick and read only after the strobe has dropped. Status and edge pulses appear at the edge where the counter leaves the comparator value. Status is read back after the tick burst, and pulses are tallied by a falling-edge monitor on `evt`.

// File: rtl/et_pkg.sv
package et_pkg;
    localparam int MIN_CHANNELS = 3;
    localparam int WINDOW_SLOTS = 24;

    // word offsets (addr[9:2]) of the global registers
    localparam logic [7:0] W_CAP_LO  = 8'h00;
    localparam logic [7:0] W_CAP_HI  = 8'h01;
    localparam logic [7:0] W_GCFG_LO = 8'h04;
    localparam logic [7:0] W_GCFG_HI = 8'h05;
    localparam logic [7:0] W_STAT    = 8'h08;
    localparam logic [7:0] W_CNT_LO  = 8'h3C;
    localparam logic [7:0] W_CNT_HI  = 8'h3D;

    // word offsets (addr[4:2]) inside a channel slot
    localparam logic [2:0] C_CFG_LO = 3'd0;
    localparam logic [2:0] C_CFG_HI = 3'd1;
    localparam logic [2:0] C_CMP_LO = 3'd2;
    localparam logic [2:0] C_CMP_HI = 3'd3;
    localparam logic [2:0] C_RT_LO  = 3'd4;
    localparam logic [2:0] C_RT_HI  = 3'd5;

    localparam logic [31:0] CH_CAP_HI = 32'h0000_0004;

    function automatic int clamp_nt(input int req_n, input int max_n);
        int lim;
        lim = (max_n > WINDOW_SLOTS) ? WINDOW_SLOTS : max_n;
        if (req_n < MIN_CHANNELS) return MIN_CHANNELS;
        if (req_n > lim) return lim;
        return req_n;
    endfunction

    typedef struct packed {
        logic        level;
        logic        ena;
        logic        per;
        logic [63:0] cmp;
        logic [63:0] rt;
        logic        armed;
        logic        stat;
        logic        pulse;
    } ch_state_t;

    typedef struct packed {
        logic [1:0]  gcfg;
        logic        rvalid;
        logic [31:0] rdata;
    } fe_state_t;
endpackage

// File: rtl/et_main_counter.sv
module et_main_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         lo_we,
    input  logic         hi_we,
    input  logic [31:0]  wdata,
    output logic [W-1:0] count
);
    localparam int HW = W / 2;

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (lo_we || hi_we) begin
            if (lo_we) count_d[HW-1:0] = wdata[HW-1:0];
            if (hi_we) count_d[W-1:HW] = wdata[HW-1:0];
        end else if (run) begin
            count_d = count_q + {{(W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/et_channel.sv
module et_channel
    import et_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_we,
    input  logic [2:0]  word,
    input  logic [31:0] wdata,
    input  logic        glb_en,
    input  logic        glb_rise,
    input  logic        glb_fall,
    input  logic        adv,
    input  logic [63:0] count,
    input  logic        stat_clr,
    output logic [31:0] cfg_word,
    output logic [63:0] cmp,
    output logic [63:0] route,
    output logic        stat,
    output logic        evt
);
    ch_state_t s_d, s_q;
    logic      hit;
    logic      cmp_wr;

    assign hit    = s_q.armed && s_q.ena && adv && (count == s_q.cmp);
    assign cmp_wr = sel_we && (word == C_CMP_LO || word == C_CMP_HI);

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;

        if (sel_we) begin
            case (word)
                C_CFG_LO: begin
                    s_d.level = wdata[1];
                    s_d.ena   = wdata[2];
                    s_d.per   = wdata[3];
                end
                C_CMP_LO: s_d.cmp[31:0]  = wdata;
                C_CMP_HI: s_d.cmp[63:32] = wdata;
                C_RT_LO:  s_d.rt[31:0]   = wdata;
                C_RT_HI:  s_d.rt[63:32]  = wdata;
                default: ;
            endcase
        end

        if (glb_fall) begin
            s_d.armed = 1'b0;
        end else if (glb_rise) begin
            s_d.armed = (s_q.cmp != '1);
        end else if (cmp_wr && glb_en) begin
            s_d.armed = (s_d.cmp != '1);
        end

        if (stat_clr) s_d.stat = 1'b0;
        if (hit) begin
            if (s_q.level) s_d.stat  = 1'b1;
            else           s_d.pulse = 1'b1;
        end
        if (glb_fall) s_d.stat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.cmp   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_word = {26'd0, 1'b1, 1'b1, s_q.per, s_q.ena, s_q.level, 1'b0};
    assign cmp      = s_q.cmp;
    assign route    = s_q.rt;
    assign stat     = s_q.stat;
    assign evt      = s_q.level ? s_q.stat : s_q.pulse;
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import et_pkg::*;
#(
    parameter int          NUM_TIMERS  = 3,
    parameter int          MAX_TIMERS  = 24,
    parameter logic [31:0] TICK_PERIOD = 32'h0098_9680
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        req,
    input  logic        we,
    input  logic [9:0]  addr,
    input  logic [31:0] wdata,
    output logic        rvalid,
    output logic [31:0] rdata,
    output logic [et_pkg::clamp_nt(NUM_TIMERS, MAX_TIMERS)-1:0] evt
);
    localparam int NT = clamp_nt(NUM_TIMERS, MAX_TIMERS);
    localparam logic [4:0]  NT_M1  = 5'(NT - 1);
    localparam logic [31:0] CAP_LO = {18'd0, 1'b1, NT_M1, 8'h01};

    fe_state_t st_d, st_q;

    logic [7:0]    word;
    logic [2:0]    tword;
    logic [4:0]    tidx;
    logic          in_tmr;
    logic          tmr_ok;
    logic          wr;
    logic          glb_en_q;
    logic          glb_rise;
    logic          glb_fall;
    logic [63:0]   count_q;
    logic [NT-1:0] status_q;
    logic [1:0]    unused_addr_lsb;

    logic [31:0] ch_cfg [NT];
    logic [63:0] ch_cmp [NT];
    logic [63:0] ch_rt  [NT];

    assign word            = addr[9:2];
    assign tword           = addr[4:2];
    assign tidx            = addr[9:5] - 5'd8;
    assign in_tmr          = (addr[9:8] != 2'b00);
    assign tmr_ok          = in_tmr && (int'(tidx) < NT);
    assign wr              = req && we;
    assign unused_addr_lsb = addr[1:0];
    assign glb_en_q        = st_q.gcfg[0];
    assign glb_rise        = !st_q.gcfg[0] && st_d.gcfg[0];
    assign glb_fall        = st_q.gcfg[0] && !st_d.gcfg[0];

    et_main_counter #(.W(64)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (glb_en_q && tick),
        .lo_we (wr && !in_tmr && word == W_CNT_LO),
        .hi_we (wr && !in_tmr && word == W_CNT_HI),
        .wdata (wdata),
        .count (count_q)
    );

    for (genvar i = 0; i < NT; i++) begin : g_ch
        et_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_we   (wr && tmr_ok && tidx == 5'(i)),
            .word     (tword),
            .wdata    (wdata),
            .glb_en   (glb_en_q),
            .glb_rise (glb_rise),
            .glb_fall (glb_fall),
            .adv      (glb_en_q && tick),
            .count    (count_q),
            .stat_clr (wr && !in_tmr && word == W_STAT && wdata[i]),
            .cfg_word (ch_cfg[i]),
            .cmp      (ch_cmp[i]),
            .route    (ch_rt[i]),
            .stat     (status_q[i]),
            .evt      (evt[i])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = req;
        st_d.rdata  = 32'd0;

        if (wr && !in_tmr && word == W_GCFG_LO) st_d.gcfg = wdata[1:0];

        if (req && !we) begin
            if (in_tmr) begin
                for (int i = 0; i < NT; i++) begin
                    if (tmr_ok && tidx == 5'(i)) begin
                        case (tword)
                            C_CFG_LO: st_d.rdata = ch_cfg[i];
                            C_CFG_HI: st_d.rdata = CH_CAP_HI;
                            C_CMP_LO: st_d.rdata = ch_cmp[i][31:0];
                            C_CMP_HI: st_d.rdata = ch_cmp[i][63:32];
                            C_RT_LO:  st_d.rdata = ch_rt[i][31:0];
                            C_RT_HI:  st_d.rdata = ch_rt[i][63:32];
                            default:  st_d.rdata = 32'd0;
                        endcase
                    end
                end
            end else begin
                case (word)
                    W_CAP_LO:  st_d.rdata = CAP_LO;
                    W_CAP_HI:  st_d.rdata = TICK_PERIOD;
                    W_GCFG_LO: st_d.rdata = {30'd0, st_q.gcfg};
                    W_STAT:    st_d.rdata = 32'(status_q);
                    W_CNT_LO:  st_d.rdata = count_q[31:0];
                    W_CNT_HI:  st_d.rdata = count_q[63:32];
                    default:   st_d.rdata = 32'd0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rdata;
endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk #(
    parameter int NT = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          req,
    input logic          we,
    input logic [9:0]    addr,
    input logic          rvalid,
    input logic [31:0]   rdata,
    input logic [63:0]   count_q,
    input logic          glb_en_q,
    input logic [NT-1:0] status_q
);
    logic ctr_wr;
    logic oor;

    assign ctr_wr = req && we && (addr[9:3] == 7'h1E);
    assign oor    = (addr[9:8] != 2'b00) && (int'(addr[9:5]) - 8 >= NT);

    assert_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rvalid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rvalid);
    assert_cap_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr[9:2] == 8'h00) |=> (rdata[12:8] == 5'(NT - 1)));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_q && !ctr_wr) |=> $stable(count_q));
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_q && tick && !ctr_wr) |=> (count_q == $past(count_q) + 64'd1));
    assert_oor_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && oor) |=> (rdata == 32'd0));
    assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glb_en_q) |-> (status_q == '0));
    assert_set_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q)) != '0) |-> $past(glb_en_q));
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.NT(NT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .req      (req),
    .we       (we),
    .addr     (addr),
    .rvalid   (rvalid),
    .rdata    (rdata),
    .count_q  (count_q),
    .glb_en_q (glb_en_q),
    .status_q (status_q)
);

// File: tb/tb_evt_timer_regs.sv
module tb_evt_timer_regs;
    localparam int NT = 3;
    localparam logic [31:0] PERIOD = 32'h0098_9680;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        rvalid;
    logic [31:0] rdata;
    logic [NT-1:0] evt;

    int errors = 0;
    int checks = 0;
    int pulses1 = 0;
    bit done = 0;
    logic [63:0] m_cnt = '0;
    bit m_en = 0;

    always #5 clk = ~clk;

    evt_timer_regs #(.NUM_TIMERS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rvalid(rvalid), .rdata(rdata), .evt(evt)
    );

    always @(negedge clk) if (rst_n && evt[1]) pulses1++;

    function automatic logic [9:0] tad(input int n, input int w);
        return 10'(32'h100 + 32'h20 * n + 4 * w);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [9:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        chk("R2 rvalid", 64'(rvalid), 64'd1);
        r = rdata;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        logic [31:0] r;
        acc(1'b1, a, d, r);
    endtask

    task automatic rdchk(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] r;
        acc(1'b0, a, 32'd0, r);
        chk(tag, 64'(r), 64'(exp));
    endtask

    task automatic cnt_chk(input string tag);
        logic [31:0] lo, hi;
        acc(1'b0, 10'h0F0, 32'd0, lo);
        acc(1'b0, 10'h0F4, 32'd0, hi);
        chk(tag, {hi, lo}, m_cnt);
    endtask

    task automatic run(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
            if (m_en) m_cnt = m_cnt + 64'(n);
        end
    endtask

    task automatic set_en(input bit e);
        wr(10'h010, {31'd0, e});
        m_en = e;
    endtask

    task automatic set_cnt(input logic [63:0] v);
        wr(10'h0F0, v[31:0]);
        wr(10'h0F4, v[63:32]);
        m_cnt = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rvalid", 64'(rvalid), 64'd0);
        chk("R1 evt", 64'(evt), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cnt_chk("R1 counter");
        rdchk("R1 gcfg", 10'h010, 32'd0);
        rdchk("R1 status", 10'h020, 32'd0);
        for (int n = 0; n < NT; n++) begin
            rdchk("R1 cmp lo", tad(n, 2), 32'hFFFF_FFFF);
            rdchk("R1 cmp hi", tad(n, 3), 32'hFFFF_FFFF);
        end
        @(negedge clk);
        chk("R2 idle", 64'(rvalid), 64'd0);

        // R3 capability
        rdchk("R3 cap lo", 10'h000, 32'h0000_2201);
        rdchk("R3 cap hi", 10'h004, PERIOD);
        wr(10'h000, 32'h1234_5678);
        wr(10'h004, 32'h0);
        rdchk("R3 cap lo after write", 10'h000, 32'h0000_2201);
        rdchk("R3 cap hi after write", 10'h004, PERIOD);

        // R6 global config mask
        wr(10'h010, 32'hFFFF_FFFE);
        rdchk("R6 gcfg mask", 10'h010, 32'h2);
        wr(10'h014, 32'hFFFF_FFFF);
        rdchk("R6 gcfg hi", 10'h014, 32'h0);
        wr(10'h010, 32'h0);

        // R4 hold / count / carry, R5 writes
        set_cnt({32'hA5A5_0001, 32'h0000_1000});
        run(7);
        cnt_chk("R4 hold while stopped");
        set_en(1);
        run(9);
        cnt_chk("R4 count nine ticks");
        set_cnt({32'h0000_0000, 32'hFFFF_FFFF});
        cnt_chk("R5 write while running");
        run(1);
        cnt_chk("R4 carry into high half");
        for (int k = 0; k < 12; k++) begin
            set_en($urandom_range(0, 1) == 1);
            set_cnt({$urandom(), $urandom()});
            run(int'($urandom_range(0, 15)));
            cnt_chk("R4 R5 random");
        end
        set_en(0);

        // R7 R8 channel registers
        for (int n = 0; n < NT; n++) begin
            logic [31:0] a, b, c, d;
            a = $urandom(); b = $urandom(); c = $urandom(); d = $urandom();
            wr(tad(n, 2), a); wr(tad(n, 3), b);
            wr(tad(n, 4), c); wr(tad(n, 5), d);
            rdchk("R7 cmp lo", tad(n, 2), a);
            rdchk("R7 cmp hi", tad(n, 3), b);
            rdchk("R7 route lo", tad(n, 4), c);
            rdchk("R7 route hi", tad(n, 5), d);
            wr(tad(n, 0), 32'hFFFF_FFFF);
            rdchk("R8 cfg mask", tad(n, 0), 32'h0000_003E);
            wr(tad(n, 1), 32'h0);
            rdchk("R8 cfg hi", tad(n, 1), 32'h4);
            wr(tad(n, 0), 32'h0);
            rdchk("R8 cfg cleared", tad(n, 0), 32'h0000_0030);
        end

        // R9 out of range
        wr(tad(NT - 1, 4), 32'h0BAD_F00D);
        wr(tad(NT, 4), 32'hDEAD_BEEF);
        rdchk("R9 oor read", tad(NT, 4), 32'h0);
        rdchk("R9 last slot untouched", tad(NT - 1, 4), 32'h0BAD_F00D);
        rdchk("R9 unmapped", 10'h030, 32'h0);

        // R11 level and edge firing
        set_cnt(64'd0);
        wr(tad(0, 2), 32'd5); wr(tad(0, 3), 32'd0);
        wr(tad(1, 2), 32'd3); wr(tad(1, 3), 32'd0);
        wr(tad(2, 0), 32'h0);
        wr(tad(0, 0), 32'h6);
        wr(tad(1, 0), 32'h4);
        pulses1 = 0;
        set_en(1);
        run(10);
        rdchk("R11 level sets status", 10'h020, 32'h1);
        chk("R11 evt level", 64'(evt[0]), 64'd1);
        chk("R11 edge one pulse", 64'(pulses1), 64'd1);

        // R12 write-one-to-clear
        wr(10'h020, 32'h0);
        rdchk("R12 zero write keeps", 10'h020, 32'h1);
        wr(10'h020, 32'hFFFF_FFFE);
        rdchk("R12 other bits keep", 10'h020, 32'h1);
        wr(10'h020, 32'h1);
        rdchk("R12 one clears", 10'h020, 32'h0);
        chk("R12 evt drops", 64'(evt[0]), 64'd0);

        // R10 stop clears status
        set_cnt(64'd4);
        run(3);
        rdchk("R10 status before stop", 10'h020, 32'h1);
        set_en(0);
        rdchk("R10 stop clears", 10'h020, 32'h0);

        // R10 all-ones comparator not armed
        set_cnt(64'hFFFF_FFFF_FFFF_FFFD);
        wr(tad(0, 2), 32'hFFFF_FFFF); wr(tad(0, 3), 32'hFFFF_FFFF);
        wr(tad(2, 2), 32'hFFFF_FFFE); wr(tad(2, 3), 32'hFFFF_FFFF);
        wr(tad(2, 0), 32'h6);
        set_en(1);
        run(4);
        rdchk("R10 all-ones unarmed", 10'h020, 32'h4);
        cnt_chk("R4 wrap to one");

        // R10 comparator write while running arms
        pulses1 = 0;
        wr(tad(0, 3), 32'd0);
        wr(tad(0, 2), 32'd3);
        run(3);
        rdchk("R10 write arms", 10'h020, 32'h5);
        chk("R11 edge pulse again", 64'(pulses1), 64'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule